// File: doc/BRIEF.md
# Four-Leg Offset-Injection PWM Modulator

This block turns three per-phase voltage commands into switching commands for a four-leg inverter. Each command is signed and measured from the midpoint of the fourth (neutral) leg. A free common-mode offset is added to the three commands to form the phase-leg modulation signals, and the fourth leg is modulated by the offset alone. Line-to-line and line-to-neutral averages therefore do not depend on the offset, and its choice only moves time between the two zero states. The offset is chosen between an upper and a lower bound. These bounds keep every leg inside half the DC bus. The choice follows one of three partitioning rules: centred between the bounds, clamped to the bound with the larger magnitude, or clamped so that the extreme-voltage leg carrying more current stops switching.

The four modulation values are compared with one shared up/down triangular carrier. New values are taken only when the carrier turns at its peak or valley, so a leg never sees a partial pulse. Values that the bounds cannot hold, as in overmodulation, are saturated to the carrier range. A control loop drives the commands and the current samples. It uses the update strobe as its period tick and reads the carrier value to time its sampling.

Top module: `fl_offset_pwm`

## Requirements
- R1: After reset the carrier starts at -HALF_BUS counting up. It moves by exactly one per clock between -HALF_BUS and +HALF_BUS, reverses at each end, and so repeats every 4*HALF_BUS cycles.
- R2: The update strobe is high exactly in the cycles where the carrier sits at +HALF_BUS or -HALF_BUS. The latched modulation values take new data only on the clock edge that ends such a cycle and hold in all other cycles.
- R3: Gate bit k is high while latched modulation value k is strictly greater than the carrier. Bit 0 is phase a, bit 1 phase b, bit 2 phase c and bit 3 the neutral leg.
- R4: Phase modulation value = phase command + offset, and neutral modulation value = offset. Each is saturated to [-HALF_BUS, +HALF_BUS].
- R5: With vmax/vmin the largest and smallest command, the upper bound is HALF_BUS when vmax < 0, else HALF_BUS - vmax. The lower bound is -HALF_BUS when vmin > 0, else -HALF_BUS - vmin.
- R6: Mode 0 (and mode 3) is centred: offset = floor((upper + lower) / 2).
- R7: Mode 1 clamps by voltage: offset = upper bound when |upper| >= |lower|, otherwise the lower bound.
- R8: Mode 2 clamps by current: offset = upper bound when |current of the vmax phase| >= |current of the vmin phase|, otherwise the lower bound. For equal commands, the earlier phase (a before b before c) is taken as the vmax or vmin phase.
- R9: In reset and until the first update, all modulation values are zero. All four gates are then high at the valley, and the neutral leg runs at 50 % duty.
- R10: In modes 1 and 2, when the bounds do not cross, at least one latched modulation value sits at +HALF_BUS or -HALF_BUS. That leg does not switch for the whole period.
- R11: In modes 0, 1 and 3 the current inputs have no effect on any gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Partitioning rule: 0 centred, 1 voltage clamp, 2 current clamp, 3 centred |
| cmd_a_i | input | DW | Signed phase a voltage command |
| cmd_b_i | input | DW | Signed phase b voltage command |
| cmd_c_i | input | DW | Signed phase c voltage command |
| cur_a_i | input | IW | Signed phase a current sample |
| cur_b_i | input | IW | Signed phase b current sample |
| cur_c_i | input | IW | Signed phase c current sample |
| gate_o | output | 4 | Leg commands {neutral, c, b, a} |
| carrier_o | output | DW+2 | Signed triangular carrier count |
| upd_o | output | 1 | High while the carrier is at a turning point |

## Verification
The bench builds the block with DW = 10, IW = 10 and HALF_BUS = 48, which gives a 192-cycle carrier period. That is short enough to run a few hundred periods, each with a fresh command set and mode. Commands are drawn from +/-60, so most periods stay inside the bounds and a good share cross them. Both the saturation path and the rail-clamped leg are therefore exercised. Directed periods cover all-positive and all-negative command sets, equal commands, current-magnitude ties and pairs of periods that differ only in their currents.

// File: rtl/fl_pwm_pkg.sv
package fl_pwm_pkg;

  typedef enum logic [1:0] {
    OFS_CENTRED     = 2'd0,
    OFS_VCLAMP      = 2'd1,
    OFS_ICLAMP      = 2'd2,
    OFS_CENTRED_ALT = 2'd3
  } ofs_mode_e;

  // Magnitude of a signed value.
  function automatic int f_abs(input int x);
    return (x < 0) ? -x : x;
  endfunction

  // Saturate x to the symmetric range [-h, h].
  function automatic int f_clip(input int x, input int h);
    if (x > h)  return h;
    if (x < -h) return -h;
    return x;
  endfunction

  // Highest offset that keeps the largest command on or below the top rail.
  function automatic int f_upper(input int vmax, input int h);
    return (vmax < 0) ? h : h - vmax;
  endfunction

  // Lowest offset that keeps the smallest command on or above the bottom rail.
  function automatic int f_lower(input int vmin, input int h);
    return (vmin > 0) ? -h : -h - vmin;
  endfunction

  // Halve with rounding toward minus infinity.
  function automatic int f_half_floor(input int s);
    return s >>> 1;
  endfunction

endpackage

// File: rtl/fl_carrier.sv
module fl_carrier #(
  parameter int HALF_BUS = 1000,
  parameter int CW       = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic signed [CW-1:0] cnt_o,
  output logic                 turn_o
);

  localparam logic signed [CW-1:0] PEAK     = CW'(HALF_BUS);
  localparam logic signed [CW-1:0] VALLEY   = CW'(-HALF_BUS);
  localparam logic signed [CW-1:0] PEAK_M1  = CW'(HALF_BUS - 1);
  localparam logic signed [CW-1:0] VALL_P1  = CW'(1 - HALF_BUS);
  localparam logic signed [CW-1:0] STEP     = CW'(1);

  logic signed [CW-1:0] cnt_q;
  logic                 up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= VALLEY;
      up_q  <= 1'b1;
    end else if (up_q) begin
      cnt_q <= cnt_q + STEP;
      if (cnt_q == PEAK_M1) up_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - STEP;
      if (cnt_q == VALL_P1) up_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign turn_o = (cnt_q == PEAK) || (cnt_q == VALLEY);

endmodule

// File: rtl/fl_extreme_sel.sv
module fl_extreme_sel #(
  parameter int DW = 12,
  parameter int IW = 12
) (
  input  logic signed [DW-1:0] cmd_i [3],
  input  logic signed [IW-1:0] cur_i [3],
  output logic signed [DW-1:0] vmax_o,
  output logic signed [DW-1:0] vmin_o,
  output logic        [IW:0]   mag_at_max_o,
  output logic        [IW:0]   mag_at_min_o
);

  localparam logic [IW:0] ONE_M = 1;

  logic [IW:0] mag [3];

  // Current magnitude, one extra bit so the most negative code fits.
  for (genvar g = 0; g < 3; g++) begin : g_mag
    logic [IW:0] ext;
    assign ext    = {cur_i[g][IW-1], cur_i[g]};
    assign mag[g] = ext[IW] ? (~ext + ONE_M) : ext;
  end

  // Strict comparisons: the earliest phase wins a tie.
  always_comb begin
    vmax_o       = cmd_i[0];
    vmin_o       = cmd_i[0];
    mag_at_max_o = mag[0];
    mag_at_min_o = mag[0];
    for (int k = 1; k < 3; k++) begin
      if (cmd_i[k] > vmax_o) begin
        vmax_o       = cmd_i[k];
        mag_at_max_o = mag[k];
      end
      if (cmd_i[k] < vmin_o) begin
        vmin_o       = cmd_i[k];
        mag_at_min_o = mag[k];
      end
    end
  end

endmodule

// File: rtl/fl_offset_calc.sv
module fl_offset_calc
  import fl_pwm_pkg::*;
#(
  parameter int DW       = 12,
  parameter int IW       = 12,
  parameter int HALF_BUS = 1000,
  parameter int MW       = 14
) (
  input  logic                 [1:0]    mode_i,
  input  logic signed          [DW-1:0] vmax_i,
  input  logic signed          [DW-1:0] vmin_i,
  input  logic                 [IW:0]   mag_at_max_i,
  input  logic                 [IW:0]   mag_at_min_i,
  output logic signed          [MW-1:0] offset_o,
  output logic                          crossed_o
);

  int  upper;
  int  lower;
  int  ofs;
  logic take_lower;

  always_comb begin
    upper      = f_upper(int'(vmax_i), HALF_BUS);
    lower      = f_lower(int'(vmin_i), HALF_BUS);
    take_lower = 1'b0;
    case (ofs_mode_e'(mode_i))
      OFS_VCLAMP: begin
        take_lower = f_abs(lower) > f_abs(upper);
        ofs        = take_lower ? lower : upper;
      end
      OFS_ICLAMP: begin
        take_lower = mag_at_min_i > mag_at_max_i;
        ofs        = take_lower ? lower : upper;
      end
      default: ofs = f_half_floor(upper + lower);
    endcase
  end

  assign offset_o  = MW'(ofs);
  assign crossed_o = upper < lower;

endmodule

// File: rtl/fl_leg_stage.sv
module fl_leg_stage
  import fl_pwm_pkg::*;
#(
  parameter int HALF_BUS = 1000,
  parameter int MW       = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic signed [MW-1:0] cmd_i,
  input  logic signed [MW-1:0] offset_i,
  input  logic signed [MW-1:0] carrier_i,
  output logic signed [MW-1:0] mod_o,
  output logic                 gate_o
);

  logic signed [MW-1:0] mod_nxt;
  logic signed [MW-1:0] mod_q;

  assign mod_nxt = MW'(f_clip(int'(cmd_i) + int'(offset_i), HALF_BUS));

  // Only a carrier turning point may load a new value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mod_q <= '0;
    else if (load_i) mod_q <= mod_nxt;
  end

  assign mod_o  = mod_q;
  assign gate_o = mod_q > carrier_i;

endmodule

// File: rtl/fl_offset_pwm.sv
module fl_offset_pwm
  import fl_pwm_pkg::*;
#(
  parameter int DW       = 12,
  parameter int IW       = 12,
  parameter int HALF_BUS = 1000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_i,
  input  logic signed [DW-1:0] cmd_a_i,
  input  logic signed [DW-1:0] cmd_b_i,
  input  logic signed [DW-1:0] cmd_c_i,
  input  logic signed [IW-1:0] cur_a_i,
  input  logic signed [IW-1:0] cur_b_i,
  input  logic signed [IW-1:0] cur_c_i,
  output logic [3:0]           gate_o,
  output logic signed [DW+1:0] carrier_o,
  output logic                 upd_o
);

  localparam int MW    = DW + 2;
  localparam int NLEGS = 4;

  logic signed [DW-1:0] cmd_v [3];
  logic signed [IW-1:0] cur_v [3];
  logic signed [DW-1:0] vmax_w;
  logic signed [DW-1:0] vmin_w;
  logic        [IW:0]   mag_max_w;
  logic        [IW:0]   mag_min_w;
  logic signed [MW-1:0] offset_w;
  logic                 crossed_w;
  logic signed [MW-1:0] car_w;
  logic                 turn_w;
  logic signed [MW-1:0] leg_cmd [NLEGS];
  logic signed [MW-1:0] leg_mod [NLEGS];
  logic [NLEGS*MW-1:0]  mod_flat;
  logic [1:0]           mode_q;
  logic                 crossed_q;

  assign cmd_v[0] = cmd_a_i;
  assign cmd_v[1] = cmd_b_i;
  assign cmd_v[2] = cmd_c_i;
  assign cur_v[0] = cur_a_i;
  assign cur_v[1] = cur_b_i;
  assign cur_v[2] = cur_c_i;

  fl_carrier #(.HALF_BUS(HALF_BUS), .CW(MW)) carrier_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_o  (car_w),
    .turn_o (turn_w)
  );

  fl_extreme_sel #(.DW(DW), .IW(IW)) extreme_i (
    .cmd_i        (cmd_v),
    .cur_i        (cur_v),
    .vmax_o       (vmax_w),
    .vmin_o       (vmin_w),
    .mag_at_max_o (mag_max_w),
    .mag_at_min_o (mag_min_w)
  );

  fl_offset_calc #(.DW(DW), .IW(IW), .HALF_BUS(HALF_BUS), .MW(MW)) offset_i (
    .mode_i       (mode_i),
    .vmax_i       (vmax_w),
    .vmin_i       (vmin_w),
    .mag_at_max_i (mag_max_w),
    .mag_at_min_i (mag_min_w),
    .offset_o     (offset_w),
    .crossed_o    (crossed_w)
  );

  // Phase legs take their command, the neutral leg takes zero.
  for (genvar g = 0; g < NLEGS; g++) begin : g_leg
    if (g < 3) begin : g_phase
      assign leg_cmd[g] = MW'(cmd_v[g]);
    end else begin : g_neutral
      assign leg_cmd[g] = '0;
    end

    fl_leg_stage #(.HALF_BUS(HALF_BUS), .MW(MW)) stage_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (turn_w),
      .cmd_i     (leg_cmd[g]),
      .offset_i  (offset_w),
      .carrier_i (car_w),
      .mod_o     (leg_mod[g]),
      .gate_o    (gate_o[g])
    );

    assign mod_flat[g*MW +: MW] = leg_mod[g];
  end

  // Rule and bound state of the period now running, for the checker.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= 2'd0;
      crossed_q <= 1'b0;
    end else if (turn_w) begin
      mode_q    <= mode_i;
      crossed_q <= crossed_w;
    end
  end

  assign carrier_o = car_w;
  assign upd_o     = turn_w;

endmodule

// File: rtl/fl_offset_pwm_chk.sv
module fl_offset_pwm_chk #(
  parameter int MW       = 14,
  parameter int HALF_BUS = 1000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic signed [MW-1:0] carrier,
  input logic                 upd,
  input logic [3:0]           gate,
  input logic [4*MW-1:0]      mod_flat,
  input logic [1:0]           mode_q,
  input logic                 crossed_q
);

  localparam logic signed [MW-1:0] PK   = MW'(HALF_BUS);
  localparam logic signed [MW-1:0] VL   = MW'(-HALF_BUS);
  localparam logic signed [MW-1:0] STEP = MW'(1);

  logic ran_q;
  logic any_rail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ran_q <= 1'b0;
    else        ran_q <= 1'b1;
  end

  always_comb begin
    any_rail = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if ($signed(mod_flat[k*MW +: MW]) == PK || $signed(mod_flat[k*MW +: MW]) == VL)
        any_rail = 1'b1;
    end
  end

  AST_CARRIER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier <= PK) && (carrier >= VL)); // R1

  AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ran_q |-> ((carrier == $past(carrier) + STEP) || (carrier == $past(carrier) - STEP))); // R1

  AST_MOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ran_q && !$past(upd)) |-> $stable(mod_flat)); // R2

  AST_PEAK_GATES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier == PK) |-> (gate == 4'b0000)); // R3

  for (genvar g = 0; g < 4; g++) begin : g_bound
    AST_MOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(mod_flat[g*MW +: MW]) <= PK) && ($signed(mod_flat[g*MW +: MW]) >= VL)); // R4
  end

  AST_CLAMP_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (((mode_q == 2'd1) || (mode_q == 2'd2)) && !crossed_q) |-> any_rail); // R10

endmodule

bind fl_offset_pwm fl_offset_pwm_chk #(.MW(MW), .HALF_BUS(HALF_BUS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .carrier   (car_w),
  .upd       (turn_w),
  .gate      (gate_o),
  .mod_flat  (mod_flat),
  .mode_q    (mode_q),
  .crossed_q (crossed_q)
);

// File: tb/fl_offset_pwm_tb_top.sv
`timescale 1ns/1ps
module fl_offset_pwm_tb_top;

  localparam int DW = 10;
  localparam int IW = 10;
  localparam int H  = 48;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [1:0]           mode;
  logic signed [DW-1:0] ca, cb, cc;
  logic signed [IW-1:0] ia, ib, ic;
  logic [3:0]           gate_o;
  logic signed [DW+1:0] carrier_o;
  logic                 upd_o;

  int    n_chk = 0;
  int    n_err = 0;
  bit    mon_on = 1'b0;
  int    e_car;
  bit    e_up;
  int    e_mod [4];
  int    e_mode;

  always #10 clk = ~clk;

  fl_offset_pwm #(.DW(DW), .IW(IW), .HALF_BUS(H)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .cmd_a_i   (ca),
    .cmd_b_i   (cb),
    .cmd_c_i   (cc),
    .cur_a_i   (ia),
    .cur_b_i   (ib),
    .cur_c_i   (ic),
    .gate_o    (gate_o),
    .carrier_o (carrier_o),
    .upd_o     (upd_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int mag(input int x);
    return (x >= 0) ? x : -x;
  endfunction

  function automatic int sat(input int x);
    return (x > H) ? H : ((x < -H) ? -H : x);
  endfunction

  function automatic int half_down(input int s);
    return (s >= 0) ? s / 2 : -((1 - s) / 2);
  endfunction

  // Expected modulation values, derived from R4..R8.
  task automatic calc_expect();
    int v [3];
    int c [3];
    int hi, lo, up_b, lo_b, ofs;
    v[0] = int'(ca); v[1] = int'(cb); v[2] = int'(cc);
    c[0] = int'(ia); c[1] = int'(ib); c[2] = int'(ic);
    hi = 0; lo = 0;
    for (int k = 1; k < 3; k++) begin
      if (v[k] > v[hi]) hi = k;
      if (v[k] < v[lo]) lo = k;
    end
    up_b = (v[hi] >= 0) ? H - v[hi] : H;      // R5
    lo_b = (v[lo] <= 0) ? -H - v[lo] : -H;    // R5
    e_mode = int'(mode);
    if (e_mode == 1)      ofs = (mag(up_b) >= mag(lo_b)) ? up_b : lo_b;        // R7
    else if (e_mode == 2) ofs = (mag(c[hi]) >= mag(c[lo])) ? up_b : lo_b;      // R8
    else                  ofs = half_down(up_b + lo_b);                        // R6
    for (int k = 0; k < 3; k++) e_mod[k] = sat(v[k] + ofs);                   // R4
    e_mod[3] = sat(ofs);
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      chk(int'(carrier_o) == e_car, "R1 carrier", int'(carrier_o), e_car);
      chk(upd_o == ((e_car == H) || (e_car == -H)), "R2 strobe", int'(upd_o),
          ((e_car == H) || (e_car == -H)) ? 1 : 0);
      for (int l = 0; l < 4; l++) begin
        string tg;
        tg = (e_mode == 1) ? "R3 R4 R5 R7" : ((e_mode == 2) ? "R3 R4 R5 R8" : "R3 R4 R5 R6");
        if (e_mod[l] == H || e_mod[l] == -H) tg = {tg, " R10"};
        if (e_mode != 2) tg = {tg, " R11"};
        tg = {tg, $sformatf(" leg %0d car %0d", l, e_car)};
        chk(gate_o[l] == (e_mod[l] > e_car), tg, int'(gate_o[l]), (e_mod[l] > e_car) ? 1 : 0);
      end
      if ((e_car == H) || (e_car == -H)) calc_expect();
      if (e_up) begin
        e_car++;
        if (e_car == H) e_up = 1'b0;
      end else begin
        e_car--;
        if (e_car == -H) e_up = 1'b1;
      end
    end
  end

  task automatic apply(input int a, input int b, input int c,
                       input int xa, input int xb, input int xc, input int m);
    ca = DW'(a); cb = DW'(b); cc = DW'(c);
    ia = IW'(xa); ib = IW'(xb); ic = IW'(xc);
    mode = 2'(m);
    repeat (4 * H) @(posedge clk);
    #3;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    mode = 2'd0; ca = '0; cb = '0; cc = '0; ia = '0; ib = '0; ic = '0;
    e_car = -H; e_up = 1'b1; e_mode = 0;
    for (int k = 0; k < 4; k++) e_mod[k] = 0;

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(int'(carrier_o) == -H, "R9 R1 reset carrier", int'(carrier_o), -H);
    chk(gate_o == 4'b1111, "R9 reset gates", int'(gate_o), 15);
    chk(upd_o == 1'b1, "R9 R2 reset strobe", int'(upd_o), 1);

    @(posedge clk);
    #3;
    rst_n  = 1'b1;
    mon_on = 1'b1;

    // Directed corner cases.
    apply(0, 0, 0, 0, 0, 0, 0);               // R9 zero offset, neutral at half duty
    apply(30, -10, -20, 5, 0, -40, 0);        // R6
    apply(30, -10, -20, 5, 0, -40, 3);        // R6 alternate code
    apply(30, -10, -20, 5, 0, -40, 1);        // R7
    apply(30, -10, -20, 5, 0, -40, 2);        // R8 lower bound chosen
    apply(30, -10, -20, 50, 0, -4, 2);        // R8 upper bound chosen
    apply(-10, -20, -5, 0, 0, 0, 1);          // R5 all negative
    apply(10, 20, 5, 0, 0, 0, 1);             // R5 all positive
    apply(15, 15, 15, 7, -30, 2, 2);          // R8 equal commands
    apply(20, 0, -20, 20, 9, -20, 2);         // R8 current tie
    apply(60, -60, 0, 1, 2, 3, 0);            // R4 overmodulation
    apply(60, -60, 0, 1, 2, 3, 1);
    apply(60, -60, 0, 1, 2, -90, 2);
    apply(25, -5, -15, 100, -3, 0, 1);        // R11 currents A
    apply(25, -5, -15, -2, 300, -200, 1);     // R11 currents B
    apply(25, -5, -15, -2, 300, -200, 0);     // R11

    // Constrained random periods.
    for (int p = 0; p < 240; p++) begin
      apply(int'($urandom_range(120)) - 60, int'($urandom_range(120)) - 60,
            int'($urandom_range(120)) - 60,
            int'($urandom_range(800)) - 400, int'($urandom_range(800)) - 400,
            int'($urandom_range(800)) - 400, int'($urandom_range(3)));
    end

    @(negedge clk);
    mon_on = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule